// File: doc/BRIEF.md
# RSSI Power Level Classifier

This block sorts a station's received signal strength into one of four transmit power reduction levels, from normal up to the strongest reduction. Each request carries an 8-bit RSSI sample and the level the station was given last time. One cycle later the block returns the new level, a signed power offset in dB for that level, and a one-cycle valid pulse. Three thresholds set the boundaries between levels. They are written through a small programming port. Programmed values that are out of range become the "disabled" value.

Before the comparison the thresholds are adjusted in two steps. First, while the noisy flag is high, the lowest two thresholds are raised by different amounts. Second, a hysteresis gap is added to every threshold whose index is at or above the previous level. This makes it harder to climb to a stronger reduction than to stay at the current one. Both steps saturate at 0xFF.

A two-state controller sequences the result. In `S_IDLE` the block waits for a request. The transition `req` moves it to `S_DONE`, where the result is presented with valid high. From `S_DONE`, a further request (`req`) keeps it in `S_DONE`, and no request (`no_req`) returns it to `S_IDLE`.

Top module: `rssi_pwr_classifier`

## Requirements
- R1: After reset all three thresholds hold 0xFF, `res_vld` is 0, `res_lvl` is 0 and `res_ofs` is 0.
- R2: Thresholds are indexed 0, 1 and 2. The level is 3 if RSSI is at least effective threshold 2. Otherwise it is 2 if RSSI is at least effective threshold 1. Otherwise it is 1 if RSSI is at least effective threshold 0. Otherwise it is 0 (normal).
- R3: Every threshold whose index is greater than or equal to `req_last` is raised by `HYST_GAP` (default 2) before the comparison. The other thresholds are used unraised.
- R4: When `thr_we` is high, `thr_val` is written to the threshold selected by `thr_sel` (0, 1 or 2). A write with `thr_sel` = 3 changes nothing.
- R5: A written value of 0 or above 100 is stored as 0xFF. Values from 1 to 100 are stored unchanged.
- R6: When `noisy` is high in the request cycle, threshold 0 is raised by 8 and threshold 1 by 5. Threshold 2 is not changed. This bias is applied before the hysteresis gap.
- R7: Each addition saturates at 0xFF. A threshold whose effective value is 0xFF never matches, even when RSSI is 0xFF.
- R8: `res_ofs` is an 8-bit two's complement dB value: 0x00 for level 0, 0xFD (-3) for level 1, 0xF9 (-7) for level 2 and 0xF5 (-11) for level 3.
- R9: A request in cycle n gives `res_vld` high and the new result in cycle n+1. `res_vld` is low in any cycle that does not follow a request, and the result outputs hold their values until the next request.
- R10: When a threshold write and a request fall in the same cycle, the request uses the threshold value from before the write. The new value applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_we | input | 1 | Threshold write strobe |
| thr_sel | input | 2 | Threshold index to write (0..2) |
| thr_val | input | 8 | Threshold value to write |
| noisy | input | 1 | Noisy-environment bias enable, sampled with the request |
| req_vld | input | 1 | Classification request |
| req_rssi | input | 8 | RSSI sample |
| req_last | input | 2 | Previous level of the station |
| res_vld | output | 1 | One-cycle result valid pulse |
| res_lvl | output | 2 | Chosen power level |
| res_ofs | output | 8 | Signed dB offset for the level |

## Verification
A threshold write and a classification request can fall in the same cycle. The request then has to see the old stored value, not the value being written. The bench provokes this on purpose. It drives a write and a request on the same edge, choosing the RSSI so that the old and new threshold give different levels. It then issues a second request that must see the new value. Random runs also mix writes and requests freely, and the reference model updates its own copy of the thresholds only after it has computed the expected level for the request in that same cycle.

// File: rtl/pwrlvl_pkg.sv
package pwrlvl_pkg;

    localparam int LVL_W  = 2;
    localparam int NUM_TH = (1 << LVL_W) - 1;

    typedef enum logic [LVL_W-1:0] {
        LVL_NORM = 2'd0,
        LVL_1    = 2'd1,
        LVL_2    = 2'd2,
        LVL_3    = 2'd3
    } lvl_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_DONE = 1'b1
    } st_e;

    // Signed dB offset for each level, two's complement
    function automatic logic [7:0] lvl_to_ofs(lvl_e l);
        logic [7:0] o;
        unique case (l)
            LVL_NORM: o = 8'h00;
            LVL_1:    o = 8'hFD;
            LVL_2:    o = 8'hF9;
            LVL_3:    o = 8'hF5;
            default:  o = 8'h00;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/thr_bank.sv
module thr_bank #(
    parameter int W     = 8,
    parameter int NUM   = 3,
    parameter int MAXV  = 100,
    parameter int SEL_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [SEL_W-1:0]       sel,
    input  logic [W-1:0]           val,
    output logic [NUM-1:0][W-1:0]  thr
);

    localparam logic [W-1:0] DIS  = '1;
    localparam logic [W-1:0] LIM  = W'(MAXV);

    logic [W-1:0] clean;

    // Out-of-range programming collapses to the disabled code
    always_comb begin
        if (val == '0 || val > LIM) clean = DIS;
        else                        clean = val;
    end

    for (genvar i = 0; i < NUM; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)                           thr[i] <= DIS;
            else if (we && sel == SEL_W'(i))      thr[i] <= clean;
        end

        // R5: the stored value is either legal or disabled
        a_r5_stored_legal: assert property (@(posedge clk) disable iff (!rst_n)
            thr[i] != '0 && (thr[i] <= LIM || thr[i] == DIS));
    end

endmodule

// File: rtl/thr_adjust.sv
module thr_adjust #(
    parameter int W      = 8,
    parameter int NUM    = 3,
    parameter int LW     = 2,
    parameter int GAP    = 2,
    parameter int BIAS0  = 8,
    parameter int BIAS1  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM-1:0][W-1:0]  thr,
    input  logic                   noisy,
    input  logic [LW-1:0]          last,
    output logic [NUM-1:0][W-1:0]  eff
);

    localparam logic [W:0] GAP_V = (W+1)'(GAP);

    for (genvar i = 0; i < NUM; i++) begin : g_adj
        localparam int BIAS = (i == 0) ? BIAS0 : ((i == 1) ? BIAS1 : 0);
        localparam logic [W:0] BIAS_V = (W+1)'(BIAS);

        logic [W:0]   sum_n;
        logic [W-1:0] stage_n;
        logic [W:0]   sum_h;
        logic         raise;

        always_comb begin
            sum_n   = {1'b0, thr[i]} + (noisy ? BIAS_V : '0);
            stage_n = sum_n[W] ? '1 : sum_n[W-1:0];
            raise   = (int'(last) <= i);
            sum_h   = {1'b0, stage_n} + (raise ? GAP_V : '0);
            eff[i]  = sum_h[W] ? '1 : sum_h[W-1:0];
        end

        // R7: adjustment never wraps below the stored value
        a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            eff[i] >= thr[i]);
    end

    // R6: the top threshold ignores the noisy flag
    a_r6_top_unbiased: assert property (@(posedge clk) disable iff (!rst_n)
        (last == '1) |-> eff[NUM-1] == thr[NUM-1]);

endmodule

// File: rtl/level_decide.sv
module level_decide
    import pwrlvl_pkg::*;
#(
    parameter int W   = 8,
    parameter int NUM = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [W-1:0]           rssi,
    input  logic [NUM-1:0][W-1:0]  eff,
    output lvl_e                   lvl
);

    logic [NUM-1:0] hit;

    for (genvar i = 0; i < NUM; i++) begin : g_cmp
        // A threshold at the disabled code never matches
        assign hit[i] = (eff[i] != '1) && (rssi >= eff[i]);
    end

    // Highest matching threshold wins
    always_comb begin
        lvl = LVL_NORM;
        for (int i = 0; i < NUM; i++) begin
            if (hit[i]) lvl = lvl_e'(LVL_W'(i + 1));
        end
    end

    // R2: a non-normal level is only chosen when its threshold is met
    a_r2_level_met: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != LVL_NORM) |-> (rssi >= eff[int'(lvl) - 1]));

    // R7: a disabled threshold cannot be the chosen level
    a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != LVL_NORM) |-> (eff[int'(lvl) - 1] != '1));

endmodule

// File: rtl/rssi_pwr_classifier.sv
module rssi_pwr_classifier
    import pwrlvl_pkg::*;
#(
    parameter int RSSI_W    = 8,
    parameter int HYST_GAP  = 2,
    parameter int NOISY_B0  = 8,
    parameter int NOISY_B1  = 5,
    parameter int THR_LIMIT = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                thr_we,
    input  logic [1:0]          thr_sel,
    input  logic [RSSI_W-1:0]   thr_val,
    input  logic                noisy,
    input  logic                req_vld,
    input  logic [RSSI_W-1:0]   req_rssi,
    input  logic [1:0]          req_last,
    output logic                res_vld,
    output logic [1:0]          res_lvl,
    output logic [7:0]          res_ofs
);

    localparam int SEL_W = 2;

    logic [NUM_TH-1:0][RSSI_W-1:0] thr_q;
    logic [NUM_TH-1:0][RSSI_W-1:0] thr_eff;
    lvl_e                          lvl_calc;
    st_e                           st_q;
    st_e                           st_nxt;

    thr_bank #(
        .W     (RSSI_W),
        .NUM   (NUM_TH),
        .MAXV  (THR_LIMIT),
        .SEL_W (SEL_W)
    ) i_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (thr_we),
        .sel   (thr_sel),
        .val   (thr_val),
        .thr   (thr_q)
    );

    thr_adjust #(
        .W     (RSSI_W),
        .NUM   (NUM_TH),
        .LW    (LVL_W),
        .GAP   (HYST_GAP),
        .BIAS0 (NOISY_B0),
        .BIAS1 (NOISY_B1)
    ) i_adj (
        .clk   (clk),
        .rst_n (rst_n),
        .thr   (thr_q),
        .noisy (noisy),
        .last  (req_last),
        .eff   (thr_eff)
    );

    level_decide #(
        .W   (RSSI_W),
        .NUM (NUM_TH)
    ) i_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .rssi  (req_rssi),
        .eff   (thr_eff),
        .lvl   (lvl_calc)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_nxt;
    end

    // Transitions: req -> S_DONE, no_req -> S_IDLE
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            S_IDLE:  st_nxt = req_vld ? S_DONE : S_IDLE;
            S_DONE:  st_nxt = req_vld ? S_DONE : S_IDLE;
            default: st_nxt = S_IDLE;
        endcase
    end

    // Output registers, loaded only on a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lvl <= 2'(LVL_NORM);
            res_ofs <= '0;
        end else if (req_vld) begin
            res_lvl <= 2'(lvl_calc);
            res_ofs <= lvl_to_ofs(lvl_calc);
        end
    end

    assign res_vld = (st_q == S_DONE);

    // R9: every request produces a valid pulse in the next cycle
    a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> res_vld);

    // R9: valid only follows a request
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(req_vld));

    // R9: the result holds without a request
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> ($stable(res_lvl) && $stable(res_ofs)));

    // R8: the offset is one of the four legal codes
    a_r8_ofs_legal: assert property (@(posedge clk) disable iff (!rst_n)
        res_ofs == 8'h00 || res_ofs == 8'hFD || res_ofs == 8'hF9 || res_ofs == 8'hF5);

endmodule

// File: tb/test_rssi_pwr_classifier.sv
module test_rssi_pwr_classifier;

    localparam int GAP = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       thr_we = 1'b0;
    logic [1:0] thr_sel = '0;
    logic [7:0] thr_val = '0;
    logic       noisy = 1'b0;
    logic       req_vld = 1'b0;
    logic [7:0] req_rssi = '0;
    logic [1:0] req_last = '0;
    logic       res_vld;
    logic [1:0] res_lvl;
    logic [7:0] res_ofs;

    int total = 0;
    int bad = 0;
    int mthr [3];

    always #2.5 clk = ~clk;

    rssi_pwr_classifier #(.HYST_GAP(GAP)) i_rssi_pwr_classifier (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr_we   (thr_we),
        .thr_sel  (thr_sel),
        .thr_val  (thr_val),
        .noisy    (noisy),
        .req_vld  (req_vld),
        .req_rssi (req_rssi),
        .req_last (req_last),
        .res_vld  (res_vld),
        .res_lvl  (res_lvl),
        .res_ofs  (res_ofs)
    );

    function automatic int sat(int v);
        return (v > 255) ? 255 : v;
    endfunction

    function automatic int exp_lvl(int rssi, int last, bit nz);
        int lvl = 0;
        for (int i = 0; i < 3; i++) begin
            int e = mthr[i];
            if (nz && i == 0) e = sat(e + 8);
            if (nz && i == 1) e = sat(e + 5);
            if (i >= last) e = sat(e + GAP);
            if (e != 255 && rssi >= e) lvl = i + 1;
        end
        return lvl;
    endfunction

    function automatic int exp_ofs(int l);
        case (l)
            1: return 8'hFD;
            2: return 8'hF9;
            3: return 8'hF5;
            default: return 8'h00;
        endcase
    endfunction

    function automatic int clean_val(int v);
        return (v == 0 || v > 100) ? 255 : v;
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_thr(int sel, int val);
        @(negedge clk);
        thr_we = 1'b1; thr_sel = 2'(sel); thr_val = 8'(val);
        @(negedge clk);
        thr_we = 1'b0;
        if (sel < 3) mthr[sel] = clean_val(val);
    endtask

    // Request; optional same-cycle write. Expected uses thresholds before the write.
    task automatic req_check(string tag, int rssi, int last, bit nz,
                             bit wr, int wsel, int wval);
        int el;
        @(negedge clk);
        req_vld = 1'b1; req_rssi = 8'(rssi); req_last = 2'(last); noisy = nz;
        thr_we = wr; thr_sel = 2'(wsel); thr_val = 8'(wval);
        el = exp_lvl(rssi, last, nz);
        if (wr && wsel < 3) mthr[wsel] = clean_val(wval);
        @(negedge clk);
        req_vld = 1'b0; thr_we = 1'b0; noisy = 1'b0;
        chk({tag, " vld"}, int'(res_vld), 1);
        chk({tag, " lvl"}, int'(res_lvl), el);
        chk({"R8 ", tag, " ofs"}, int'(res_ofs), exp_ofs(el));
    endtask

    initial begin
        #200000;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lv;
        process::self().srandom(32'd1234);
        for (int i = 0; i < 3; i++) mthr[i] = 255;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 vld", int'(res_vld), 0);
        chk("R1 lvl", int'(res_lvl), 0);
        chk("R1 ofs", int'(res_ofs), 0);
        // R1/R7: all disabled, even full-scale RSSI stays normal
        req_check("R1 R7 disabled", 255, 3, 1'b0, 1'b0, 0, 0);

        write_thr(0, 40); write_thr(1, 60); write_thr(2, 80);
        // R2 plain comparison, no gap (last=3)
        req_check("R2 l3", 80, 3, 1'b0, 1'b0, 0, 0);
        req_check("R2 l2", 79, 3, 1'b0, 1'b0, 0, 0);
        req_check("R2 l1", 40, 3, 1'b0, 1'b0, 0, 0);
        req_check("R2 l0", 39, 3, 1'b0, 1'b0, 0, 0);
        // R3 hysteresis
        req_check("R3 all raised", 80, 0, 1'b0, 1'b0, 0, 0);
        req_check("R3 idx0 kept", 41, 1, 1'b0, 1'b0, 0, 0);
        req_check("R3 idx0 raised", 41, 0, 1'b0, 1'b0, 0, 0);
        req_check("R3 edge", 82, 0, 1'b0, 1'b0, 0, 0);
        // R6 noisy bias
        req_check("R6 t0 below", 47, 3, 1'b1, 1'b0, 0, 0);
        req_check("R6 t0 at", 48, 3, 1'b1, 1'b0, 0, 0);
        req_check("R6 t1 below", 64, 3, 1'b1, 1'b0, 0, 0);
        req_check("R6 t2 same", 80, 3, 1'b1, 1'b0, 0, 0);
        // R9: no request -> valid low, outputs hold
        @(negedge clk);
        chk("R9 vld low", int'(res_vld), 0);
        chk("R9 lvl hold", int'(res_lvl), 3);
        chk("R9 ofs hold", int'(res_ofs), 8'hF5);
        // R9: back-to-back requests each produce a result
        req_check("R9 b2b a", 60, 3, 1'b0, 1'b0, 0, 0);
        req_check("R9 b2b b", 10, 3, 1'b0, 1'b0, 0, 0);
        // R5 sanitising
        write_thr(2, 0); write_thr(1, 101);
        req_check("R5 zero and 101", 255, 3, 1'b0, 1'b0, 0, 0);
        write_thr(0, 100);
        req_check("R5 100 kept lo", 99, 3, 1'b0, 1'b0, 0, 0);
        req_check("R5 100 kept hi", 100, 3, 1'b0, 1'b0, 0, 0);
        // R4: select 3 ignored
        write_thr(3, 10);
        req_check("R4 sel3 ignored", 20, 3, 1'b0, 1'b0, 0, 0);
        // R7: disabled stays disabled under bias and gap, no wrap
        write_thr(0, 0);
        req_check("R7 sat low", 5, 0, 1'b1, 1'b0, 0, 0);
        req_check("R7 sat high", 255, 0, 1'b1, 1'b0, 0, 0);
        // R10: write and request together use the old value
        write_thr(0, 30);
        req_check("R10 old value", 35, 3, 1'b0, 1'b1, 0, 50);
        req_check("R10 new value", 35, 3, 1'b0, 1'b0, 0, 0);
        // R4 valid write path checked via R10 sequence; random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 3) == 0)
                write_thr(int'($urandom_range(0, 3)), int'($urandom_range(0, 255)));
            lv = int'($urandom_range(0, 3));
            req_check("R2 R3 R6 random", int'($urandom_range(0, 255)), lv,
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 4) == 0),
                      int'($urandom_range(0, 3)), int'($urandom_range(0, 120)));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule